// File: doc/BRIEF.md
# Quantizing Block-Length Encoder and Packer

This block compresses wavelet subband coefficients. It takes pixel pairs of 32 bits, each holding two signed 16-bit coefficients, from several subband outputs at once. Each input alternates between an even and an odd beat. On an even beat the pair is kept. On the following odd beat the kept pair and the new pair form one group of four values that lie next to each other in a single row. Every coefficient is quantized by an integer multiply with a programmable factor, followed by a fixed 8-bit right shift that rounds toward zero. One designated input carries the coarsest low-pass band and skips quantization.

Two encoder lanes process two groups per cycle. Each lane finds the two's complement width that its largest value needs and rounds that width up to one of eight bins. It emits a 3-bit bin code and then the four values at the bin width. The two lane codes are joined and appended to a wide bit buffer. Whenever 128 or more bits are waiting, the oldest 128 go out as one word. A flush request pads the last partial word with zeros.

Top module: `blkcode_packer`

## Requirements
- R1: After a synchronous reset, `outValid` is low and the bit buffer is empty, so no word appears until at least 128 code bits have been formed.
- R2: The first `inValid` beat after reset is even. Beats then alternate even and odd. An odd beat forms, for each input i, the group (even-beat low half, even-beat high half, odd-beat low half, odd-beat high half), where the low half is bits [15:0] of the pair.
- R3: A quantized value is x·f/256 truncated toward zero, where f is the input's unsigned 10-bit factor in `qFactor[10i+9:10i]`. The result is saturated to the range -32768..32767.
- R4: The input numbered `PASS_IDX` (default 0) is coded without quantization, and its factor has no effect.
- R5: The bin code is the smallest index k whose bin width is at least the largest two's complement width needed in the group. Codes 0..7 map to widths 0, 1, 2, 3, 4, 6, 8, 16. A zero value needs width 0, and -1 needs width 1.
- R6: A group code is the 3-bit bin code followed by the four values in group order, each as two's complement at the bin width. A group of all zeros is the bin code alone.
- R7: Within one odd beat, groups are coded for inputs 0,1,2,...,7 in order, one lane pair per cycle over four cycles. The stream is least-significant-bit first: the earliest bit is bit 0 of the earliest word.
- R8: Whenever 128 or more bits are buffered, the next cycle presents the oldest 128 of them on `outWord` with `outValid` high.
- R9: A `flush` pulse waits for all accepted groups to be coded. It then emits any partial word, zero-filled above the last code bit, and empties the buffer. If the buffer is empty, no word is emitted.
- R10: `inValid` pulses are at least three cycles apart.
- R11: The buffer fill never exceeds its capacity `BUF_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A new pixel pair is present on every input |
| inPairs | input | NUM_IN*32 | Pixel pairs, input i at bits [32i+31:32i], earlier coefficient in the low half |
| qFactor | input | NUM_IN*FAC_W | Quantizer factor per input, 256 means unity |
| flush | input | 1 | Request to emit the partial final word |
| outValid | output | 1 | `outWord` holds a packed word this cycle |
| outWord | output | OUT_W | Packed code stream, earliest bit at bit 0 |

## Verification
The checker watches the packing side on every cycle. It checks that a word appears exactly when 128 bits are waiting, that a flushed word is zero above the fill point and leaves the buffer empty, that the fill stays bounded, and that input beats keep their minimum spacing. Quantizer rounding and saturation, the pass-through input, bin selection, value order and the overall stream layout can only be shown by the bench. It decodes the emitted stream group by group and compares each bin code and value with its own model, using directed edge values and random coefficients and factors.

// File: rtl/blkcode_pkg.sv
package blkcode_pkg;

  localparam int PFX_W   = 3;
  localparam int SLOT_FW = 8;

  typedef struct packed {
    logic               capPrev;
    logic               snap;
    logic               work;
    logic [SLOT_FW-1:0] slot;
    logic               pad;
  } ctrl_stb_t;

  typedef struct packed {
    logic partial;
    logic empty;
  } pack_status_t;

  function automatic int binWidth(input logic [PFX_W-1:0] code);
    case (code)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 3;
      3'd4: return 4;
      3'd5: return 6;
      3'd6: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [PFX_W-1:0] binFor(input int need);
    logic [PFX_W-1:0] r;
    r = 3'd7;
    for (int i = 7; i >= 0; i--) begin
      if (binWidth(3'(i)) >= need) r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/blkcode_quant.sv
module blkcode_quant #(
  parameter int COEF_W  = 16,
  parameter int FAC_W   = 10,
  parameter int FRAC_SH = 8
) (
  input  logic [COEF_W-1:0] coef,
  input  logic [FAC_W-1:0]  fac,
  input  logic              pass,
  output logic [COEF_W-1:0] q
);
  localparam int PW = COEF_W + FAC_W + 1;
  localparam logic signed [PW-1:0] SAT_HI = {{(PW-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
  localparam logic signed [PW-1:0] SAT_LO = {{(PW-COEF_W+1){1'b1}}, {(COEF_W-1){1'b0}}};

  logic signed [PW-1:0] coefS, facS, prod, bias, biased, shifted;

  always_comb begin
    coefS   = {{(PW-COEF_W){coef[COEF_W-1]}}, coef};
    facS    = {{(PW-FAC_W){1'b0}}, fac};
    prod    = coefS * facS;
    // sign copies fill every bit below the first kept bit
    bias    = {{(PW-FRAC_SH){1'b0}}, {FRAC_SH{coef[COEF_W-1]}}};
    biased  = prod + bias;
    shifted = biased >>> FRAC_SH;
    if (pass)                 q = coef;
    else if (shifted > SAT_HI) q = SAT_HI[COEF_W-1:0];
    else if (shifted < SAT_LO) q = SAT_LO[COEF_W-1:0];
    else                       q = shifted[COEF_W-1:0];
  end
endmodule

// File: rtl/blkcode_enc.sv
module blkcode_enc
  import blkcode_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int CODE_W = PFX_W + 4 * COEF_W,
  parameter int LEN_W  = $clog2(CODE_W + 1)
) (
  input  logic [4*COEF_W-1:0] vals,
  output logic [CODE_W-1:0]   code,
  output logic [LEN_W-1:0]    codeLen
);
  int               maxW;
  int               bw;
  logic [PFX_W-1:0] sel;

  always_comb begin
    logic [COEF_W-1:0] v, m;
    int w;
    maxW = 0;
    for (int k = 0; k < 4; k++) begin
      v = vals[k*COEF_W +: COEF_W];
      m = v ^ {COEF_W{v[COEF_W-1]}};
      w = 0;
      if (v != '0) begin
        w = 1;
        for (int b = 0; b < COEF_W; b++) begin
          if (m[b]) w = b + 2;
        end
      end
      if (w > maxW) maxW = w;
    end
    sel = binFor(maxW);
    bw  = binWidth(sel);
  end

  always_comb begin
    code = '0;
    code[PFX_W-1:0] = sel;
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < COEF_W; b++) begin
        if (b < bw) code[PFX_W + k*bw + b] = vals[k*COEF_W + b];
      end
    end
    codeLen = LEN_W'(PFX_W + 4 * bw);
  end
endmodule

// File: rtl/blkcode_ctrl.sv
module blkcode_ctrl
  import blkcode_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         flush,
  input  pack_status_t stat,
  output ctrl_stb_t    stb
);
  logic               phaseOdd;
  logic               busy;
  logic [SLOT_FW-1:0] slot;
  logic               flushReq;

  always_comb begin
    stb.capPrev = inValid & ~phaseOdd;
    stb.snap    = inValid & phaseOdd;
    stb.work    = busy;
    stb.slot    = slot;
    stb.pad     = flushReq & ~busy & ~stb.snap & stat.partial;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseOdd <= 1'b0;
      busy     <= 1'b0;
      slot     <= '0;
      flushReq <= 1'b0;
    end else begin
      if (inValid) phaseOdd <= ~phaseOdd;
      if (stb.snap) begin
        busy <= 1'b1;
        slot <= '0;
      end else if (busy) begin
        if (slot == SLOT_FW'(NUM_SLOTS - 1)) busy <= 1'b0;
        else                                 slot <= slot + 1'b1;
      end
      flushReq <= (flushReq | flush) &
                  ~(stb.pad | (stat.empty & ~busy & ~stb.snap));
    end
  end
endmodule

// File: rtl/blkcode_dp.sv
module blkcode_dp
  import blkcode_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int LANES    = 2,
  parameter int COEF_W   = 16,
  parameter int FAC_W    = 10,
  parameter int FRAC_SH  = 8,
  parameter int OUT_W    = 128,
  parameter int BUF_W    = 3 * OUT_W,
  parameter int PASS_IDX = 0,
  parameter int FILL_W   = $clog2(BUF_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrl_stb_t                 stb,
  input  logic [NUM_IN*2*COEF_W-1:0] inPairs,
  input  logic [NUM_IN*FAC_W-1:0]   qFactor,
  output pack_status_t              stat,
  output logic [FILL_W-1:0]         fill,
  output logic                      outValid,
  output logic [OUT_W-1:0]          outWord
);
  localparam int PAIR_W  = 2 * COEF_W;
  localparam int CODE_W  = PFX_W + 4 * COEF_W;
  localparam int LEN_W   = $clog2(CODE_W + 1);
  localparam int MERGE_W = CODE_W * LANES;
  localparam int MLEN_W  = $clog2(MERGE_W + 1);

  logic [PAIR_W-1:0] prevBank [NUM_IN];
  logic [PAIR_W-1:0] prevW    [NUM_IN];
  logic [PAIR_W-1:0] curW     [NUM_IN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IN; i++) begin
        prevBank[i] <= '0;
        prevW[i]    <= '0;
        curW[i]     <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (stb.capPrev) prevBank[i] <= inPairs[i*PAIR_W +: PAIR_W];
        if (stb.snap) begin
          prevW[i] <= prevBank[i];
          curW[i]  <= inPairs[i*PAIR_W +: PAIR_W];
        end
      end
    end
  end

  logic [CODE_W-1:0] laneCode [LANES];
  logic [LEN_W-1:0]  laneLen  [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int                 idx;
    logic [COEF_W-1:0]  raw [4];
    logic [FAC_W-1:0]   fac;
    logic               isPass;
    logic [4*COEF_W-1:0] qv;

    always_comb begin
      idx    = int'(stb.slot) * LANES + l;
      raw[0] = prevW[idx][COEF_W-1:0];
      raw[1] = prevW[idx][PAIR_W-1:COEF_W];
      raw[2] = curW[idx][COEF_W-1:0];
      raw[3] = curW[idx][PAIR_W-1:COEF_W];
      fac    = qFactor[idx*FAC_W +: FAC_W];
      isPass = (idx == PASS_IDX);
    end

    for (genvar k = 0; k < 4; k++) begin : g_coef
      blkcode_quant #(.COEF_W(COEF_W), .FAC_W(FAC_W), .FRAC_SH(FRAC_SH)) u_quant (
        .coef (raw[k]),
        .fac  (fac),
        .pass (isPass),
        .q    (qv[k*COEF_W +: COEF_W])
      );
    end

    blkcode_enc #(.COEF_W(COEF_W), .CODE_W(CODE_W), .LEN_W(LEN_W)) u_enc (
      .vals    (qv),
      .code    (laneCode[l]),
      .codeLen (laneLen[l])
    );
  end

  logic [MERGE_W-1:0] merged;
  logic [MLEN_W-1:0]  mergedLen;

  always_comb begin
    merged    = '0;
    mergedLen = '0;
    for (int l = 0; l < LANES; l++) begin
      merged    = merged | (MERGE_W'(laneCode[l]) << mergedLen);
      mergedLen = mergedLen + MLEN_W'(laneLen[l]);
    end
  end

  logic [BUF_W-1:0]  bitBuf;
  logic [BUF_W-1:0]  keptBuf, addBits;
  logic [FILL_W-1:0] base, addLen;
  logic              emit;

  always_comb begin
    emit    = (fill >= FILL_W'(OUT_W));
    base    = emit ? fill - FILL_W'(OUT_W) : fill;
    keptBuf = emit ? (bitBuf >> OUT_W) : bitBuf;
    addBits = stb.work ? (BUF_W'(merged) << base) : '0;
    addLen  = stb.work ? FILL_W'(mergedLen) : '0;
    stat.partial = (fill != '0) && !emit;
    stat.empty   = (fill == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitBuf   <= '0;
      fill     <= '0;
      outValid <= 1'b0;
      outWord  <= '0;
    end else if (stb.pad) begin
      outValid <= 1'b1;
      outWord  <= bitBuf[OUT_W-1:0];
      bitBuf   <= '0;
      fill     <= '0;
    end else begin
      outValid <= emit;
      if (emit) outWord <= bitBuf[OUT_W-1:0];
      bitBuf <= keptBuf | addBits;
      fill   <= base + addLen;
    end
  end
endmodule

// File: rtl/blkcode_packer.sv
module blkcode_packer
  import blkcode_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int LANES    = 2,
  parameter int COEF_W   = 16,
  parameter int FAC_W    = 10,
  parameter int FRAC_SH  = 8,
  parameter int OUT_W    = 128,
  parameter int BUF_W    = 3 * OUT_W,
  parameter int PASS_IDX = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic [NUM_IN*2*COEF_W-1:0] inPairs,
  input  logic [NUM_IN*FAC_W-1:0]    qFactor,
  input  logic                       flush,
  output logic                       outValid,
  output logic [OUT_W-1:0]           outWord
);
  localparam int FILL_W    = $clog2(BUF_W + 1);
  localparam int NUM_SLOTS = NUM_IN / LANES;

  ctrl_stb_t         ctrlStb;
  pack_status_t      packStat;
  logic [FILL_W-1:0] packFill;

  blkcode_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .flush   (flush),
    .stat    (packStat),
    .stb     (ctrlStb)
  );

  blkcode_dp #(
    .NUM_IN(NUM_IN), .LANES(LANES), .COEF_W(COEF_W), .FAC_W(FAC_W),
    .FRAC_SH(FRAC_SH), .OUT_W(OUT_W), .BUF_W(BUF_W), .PASS_IDX(PASS_IDX),
    .FILL_W(FILL_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (ctrlStb),
    .inPairs  (inPairs),
    .qFactor  (qFactor),
    .stat     (packStat),
    .fill     (packFill),
    .outValid (outValid),
    .outWord  (outWord)
  );
endmodule

// File: rtl/blkcode_packer_chk.sv
module blkcode_packer_chk #(
  parameter int OUT_W  = 128,
  parameter int BUF_W  = 384,
  parameter int FILL_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              padStb,
  input logic              outValid,
  input logic [OUT_W-1:0]  outWord,
  input logic [FILL_W-1:0] packFill
);
  a_r10_in_spacing: assert property (@(posedge clk) disable iff (rst)
    inValid |-> (!$past(inValid) && !$past(inValid, 2)));

  a_r11_fill_bound: assert property (@(posedge clk) disable iff (rst)
    packFill <= FILL_W'(BUF_W));

  a_r8_word_when_full: assert property (@(posedge clk) disable iff (rst)
    (packFill >= FILL_W'(OUT_W) && !padStb) |=> outValid);

  a_r8_word_has_cause: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(padStb)) |-> ($past(packFill) >= FILL_W'(OUT_W)));

  a_r9_pad_zero_tail: assert property (@(posedge clk) disable iff (rst)
    padStb |=> (outValid && ((outWord >> $past(packFill)) == '0)));

  a_r9_pad_empties: assert property (@(posedge clk) disable iff (rst)
    padStb |=> (packFill == '0));
endmodule

bind blkcode_packer blkcode_packer_chk #(
  .OUT_W(OUT_W), .BUF_W(BUF_W), .FILL_W(FILL_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .padStb   (ctrlStb.pad),
  .outValid (outValid),
  .outWord  (outWord),
  .packFill (packFill)
);

// File: tb/tb_blkcode_packer.sv
`timescale 1ns/1ps
module tb_blkcode_packer;
  localparam int NI = 8;
  localparam int FW = 10;
  localparam int OW = 128;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic            flush = 1'b0;
  logic [NI*32-1:0] inPairs = '0;
  logic [NI*FW-1:0] qFactor = '0;
  logic            outValid;
  logic [OW-1:0]   outWord;

  blkcode_packer dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inPairs(inPairs),
    .qFactor(qFactor), .flush(flush), .outValid(outValid), .outWord(outWord)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int facM [NI];
  int prevM [NI][2];
  bit phaseM = 1'b0;
  int expVals [$];
  int expPfx [$];
  int expIn [$];
  int expBits = 0;
  bit rxBits [$];
  int wordCnt = 0;

  always @(negedge clk) begin
    if (!rst && outValid) begin
      wordCnt++;
      for (int b = 0; b < OW; b++) rxBits.push_back(outWord[b]);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int qModel(input int x, input int f, input bit pass);
    int p;
    if (pass) return x;
    p = (x * f) / 256;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  function automatic int needW(input int v);
    if (v == 0) return 0;
    for (int w = 1; w <= 16; w++)
      if (v >= -(1 << (w - 1)) && v <= (1 << (w - 1)) - 1) return w;
    return 16;
  endfunction

  function automatic int binW(input int k);
    case (k)
      0: return 0; 1: return 1; 2: return 2; 3: return 3;
      4: return 4; 5: return 6; 6: return 8; default: return 16;
    endcase
  endfunction

  function automatic int binIdx(input int w);
    for (int k = 0; k < 8; k++) if (binW(k) >= w) return k;
    return 7;
  endfunction

  function automatic int rv();
    int r;
    r = int'($urandom % 10);
    if (r < 5) return int'($urandom % 17) - 8;
    if (r < 8) return int'($urandom % 601) - 300;
    return int'($urandom % 65536) - 32768;
  endfunction

  task automatic applyFactors();
    @(negedge clk);
    for (int i = 0; i < NI; i++) qFactor[i*FW +: FW] = facM[i][FW-1:0];
  endtask

  // R2: even beat keeps pairs, odd beat forms groups in input order (R7)
  task automatic beat(input int lo[NI], input int hi[NI], input int gap);
    @(negedge clk);
    for (int i = 0; i < NI; i++) inPairs[i*32 +: 32] = {hi[i][15:0], lo[i][15:0]};
    inValid = 1'b1;
    if (!phaseM) begin
      for (int i = 0; i < NI; i++) begin prevM[i][0] = lo[i]; prevM[i][1] = hi[i]; end
    end else begin
      for (int i = 0; i < NI; i++) begin
        int v [4];
        int mw;
        int k;
        v[0] = qModel(prevM[i][0], facM[i], i == 0);
        v[1] = qModel(prevM[i][1], facM[i], i == 0);
        v[2] = qModel(lo[i], facM[i], i == 0);
        v[3] = qModel(hi[i], facM[i], i == 0);
        mw = 0;
        for (int j = 0; j < 4; j++) if (needW(v[j]) > mw) mw = needW(v[j]);
        k = binIdx(mw);
        expPfx.push_back(k);
        expIn.push_back(i);
        for (int j = 0; j < 4; j++) expVals.push_back(v[j]);
        expBits += 3 + 4 * binW(k);
      end
    end
    phaseM = ~phaseM;
    @(negedge clk);
    inValid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog actual=timeout(0) expected=done(1) %0d", 0);
    finishRun();
  end

  function automatic int getBit(input int i);
    if (i < rxBits.size()) return int'(rxBits[i]);
    return 0;
  endfunction

  initial begin
    int lo [NI];
    int hi [NI];
    int pos;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);

    // R9: flush with nothing buffered produces no word
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    repeat (10) @(negedge clk);
    chk(wordCnt == 0, "R9", "words after empty flush", wordCnt, 0);
    chk(wordCnt == 0, "R1", "no word before 128 bits", wordCnt, 0);

    // directed factors: input 0 passes (R4) even with a non-unity factor
    facM = '{77, 85, 256, 1023, 0, 128, 32, 200};
    applyFactors();
    lo = '{-32768, -7, 0, 32767, 1234, -3, -8, 0};
    hi = '{32767, 7, 0, -32768, -999, -1, 8, 0};
    beat(lo, hi, 3);
    lo = '{5, -3, 0, 100, 31000, 1, -8, 0};
    hi = '{-1, 3, 0, -100, -31000, 3, 8, 0};
    beat(lo, hi, 3);
    // all-minus-one and all-one groups at unity gain (R5 width rules)
    facM = '{256, 256, 256, 256, 256, 256, 256, 256};
    repeat (6) @(negedge clk);
    applyFactors();
    lo = '{-1, 1, -2, 2, 7, -8, 127, -129};
    hi = '{-1, 1, -2, 1, -8, 7, -128, 128};
    beat(lo, hi, 4);
    beat(lo, hi, 4);

    // random phase with periodic factor changes
    for (int blk = 0; blk < 12; blk++) begin
      repeat (8) @(negedge clk);
      for (int i = 0; i < NI; i++) facM[i] = int'($urandom % 1024);
      applyFactors();
      for (int n = 0; n < 16; n++) begin
        for (int i = 0; i < NI; i++) begin lo[i] = rv(); hi[i] = rv(); end
        beat(lo, hi, 3 + int'($urandom % 3));
      end
    end

    repeat (30) @(negedge clk);
    // R8: every full 128-bit block has been emitted, no more
    chk(wordCnt == expBits / OW, "R8", "words before flush", wordCnt, expBits / OW);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    repeat (20) @(negedge clk);
    chk(wordCnt == (expBits + OW - 1) / OW, "R9", "words after flush",
        wordCnt, (expBits + OW - 1) / OW);

    // decode the stream (R5, R6, R7, R3, R4, R2)
    pos = 0;
    for (int g = 0; g < expPfx.size(); g++) begin
      int p;
      int bw;
      bit ok;
      int badAct;
      int badExp;
      p = getBit(pos) | (getBit(pos + 1) << 1) | (getBit(pos + 2) << 2);
      pos += 3;
      chk(p == expPfx[g], "R5", $sformatf("bin code group %0d", g), p, expPfx[g]);
      bw = binW(p);
      ok = 1'b1; badAct = 0; badExp = 0;
      for (int k = 0; k < 4; k++) begin
        int val;
        val = 0;
        for (int b = 0; b < bw; b++) val |= getBit(pos + b) << b;
        if (bw > 0 && val[bw-1]) val -= (1 << bw);
        pos += bw;
        if (val != expVals[4*g + k] && ok) begin
          ok = 1'b0; badAct = val; badExp = expVals[4*g + k];
        end
      end
      chk(ok, (expIn[g] == 0) ? "R4" : "R3",
          $sformatf("R6 R2 values group %0d input %0d", g, expIn[g]), badAct, badExp);
    end
    chk(pos == expBits, "R7", "decoded bit count", pos, expBits);
    begin
      int nz;
      nz = 0;
      for (int i = pos; i < rxBits.size(); i++) nz += int'(rxBits[i]);
      chk(nz == 0, "R9", "nonzero pad bits", nz, 0);
    end
    chk(rxBits.size() - expBits < OW, "R9", "pad length", rxBits.size() - expBits, OW - 1);
    finishRun();
  end
endmodule